// File: doc/BRIEF.md
# Setup-Frame Perfect Address Filter

This block decides whether an incoming Ethernet frame is addressed to this station. Its sixteen-entry table of 48-bit station addresses is filled from a 192-byte setup frame that arrives on its own byte stream. The setup frame is made of sixteen 12-byte slots. Each slot carries one address spread over the low two bytes of each of its three 32-bit words. The loader collects the address bytes, skips the padding, and swaps the whole table in only when the frame ended on exactly its 192nd byte. A shorter or longer setup frame leaves the table as it was.

Received frames come in on a second byte stream with a start-of-frame marker. The first six bytes of a received frame are its destination address. On the sixth byte, that address is compared in parallel against every loaded entry. One clock later the block shows a decision: accept or reject. The decision holds until the next frame starts. A promiscuous input overrides the table and accepts any frame. By convention, software puts the all-ones broadcast address in slot 0. The block gives that slot no special treatment.

Top module: `stn_filter`

## Requirements
- R1: After reset `match_valid` and `match_accept` are 0. Until a complete setup frame has been loaded, every frame is rejected unless promiscuous mode is on.
- R2: A setup frame is a run of `setup_valid` bytes closed by `setup_last`. It loads the table when `setup_last` comes with byte index 191, which is the 192nd byte. Slot e spans indices 12e to 12e+11. Within a slot, the destination bytes 0 to 5 (wire order) sit at slot offsets 0, 1, 4, 5, 8 and 9. The new table is in use for any sixth destination byte taken two or more clocks after the closing setup byte.
- R3: Setup bytes at slot offsets 2, 3, 6, 7, 10 and 11 have no effect on any entry.
- R4: A setup frame whose `setup_last` comes before or after byte index 191 is discarded, and the previous table stays in use unchanged.
- R5: With promiscuous mode off, a frame whose destination equals any of the 16 loaded entries is accepted.
- R6: With promiscuous mode off, a frame whose destination equals no loaded entry is rejected.
- R7: When `promisc` is 1 at the clock that takes the sixth destination byte, the frame is accepted regardless of the table.
- R8: A received frame starts with the byte that has `rx_sof` set, and `rx_valid` gaps are allowed. `match_valid` rises on the clock after the sixth destination byte is taken. From then on, `match_valid` and `match_accept` stay unchanged until the clock that takes the next `rx_sof` byte, which clears `match_valid`.
- R9: A later complete setup frame replaces all 16 entries. Addresses present only in the earlier table are then rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| promisc | input | 1 | Accept every frame when set |
| setup_valid | input | 1 | Setup byte present |
| setup_last | input | 1 | Final byte of the setup frame |
| setup_data | input | 8 | Setup frame byte |
| rx_valid | input | 1 | Received byte present |
| rx_sof | input | 1 | First byte of a received frame |
| rx_data | input | 8 | Received frame byte |
| match_valid | output | 1 | Decision present for the current frame |
| match_accept | output | 1 | Frame accepted (meaningful while match_valid) |

## Verification
The decision is due one clock after the sixth destination byte. The bench drives every input on the falling edge. It checks on the falling edge just before that sixth byte that `match_valid` is still low. It then checks on the falling edge right after the byte that the decision is present and correct. It re-checks the decision on every later falling edge until the next frame begins, and it confirms that `match_valid` has cleared on the falling edge after the next start byte. A table load takes two clocks to reach the compare stage, so the bench leaves idle cycles after each setup frame before it sends received frames.

// File: rtl/stn_filter_pkg.sv
package stn_filter_pkg;
    localparam int ADDR_BYTES = 6;
    typedef logic [7:0] byte_t;
    typedef byte_t [ADDR_BYTES-1:0] mac_t;   // index i = wire byte i
endpackage

// File: rtl/setup_loader.sv
module setup_loader
    import stn_filter_pkg::*;
#(
    parameter int N_ENT     = 16,
    parameter int ENT_BYTES = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_last,
    input  byte_t              in_data,
    output logic               commit,
    output mac_t [N_ENT-1:0]   shadow
);
    localparam int EW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam int OW = $clog2(ENT_BYTES);

    typedef struct packed {
        logic [EW-1:0]    ent;
        logic [OW-1:0]    off;
        logic             full;
        logic             commit;
        mac_t [N_ENT-1:0] shadow;
    } ld_t;

    ld_t st_q, st_d;
    logic       at_end;
    logic       is_addr;
    logic [2:0] slot;

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        at_end  = (st_q.ent == EW'(N_ENT - 1)) && (st_q.off == OW'(ENT_BYTES - 1));
        is_addr = (st_q.off[1] == 1'b0);
        slot    = 3'((st_q.off >> 2) * 2) + {2'b00, st_q.off[0]};
        if (in_valid) begin
            if (!st_q.full && is_addr)
                st_d.shadow[st_q.ent][slot] = in_data;
            if (in_last) begin
                st_d.commit = !st_q.full && at_end;
                st_d.ent    = '0;
                st_d.off    = '0;
                st_d.full   = 1'b0;
            end else if (!st_q.full) begin
                if (at_end) begin
                    st_d.full = 1'b1;
                end else if (st_q.off == OW'(ENT_BYTES - 1)) begin
                    st_d.off = '0;
                    st_d.ent = st_q.ent + 1'b1;
                end else begin
                    st_d.off = st_q.off + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit = st_q.commit;
    assign shadow = st_q.shadow;
endmodule

// File: rtl/addr_table.sv
module addr_table
    import stn_filter_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  mac_t [N_ENT-1:0] load_tab,
    input  mac_t             cand,
    output logic             hit
);
    typedef struct packed {
        logic [N_ENT-1:0] vld;
        mac_t [N_ENT-1:0] tab;
    } tb_t;

    tb_t tb_q, tb_d;
    logic [N_ENT-1:0] eq;

    always_comb begin
        tb_d = tb_q;
        if (load) begin
            tb_d.tab = load_tab;
            tb_d.vld = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign eq[i] = tb_q.vld[i] && (tb_q.tab[i] == cand);
    end

    assign hit = |eq;
endmodule

// File: rtl/dst_capture.sv
module dst_capture
    import stn_filter_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  in_sof,
    input  byte_t in_data,
    input  logic  promisc,
    input  logic  hit,
    output mac_t  cand,
    output logic  dec_valid,
    output logic  dec_accept
);
    localparam int PW   = $clog2(ADDR_BYTES + 1);
    localparam int LAST = ADDR_BYTES - 1;

    typedef struct packed {
        logic [PW-1:0] pos;
        mac_t          bytes;
        logic          valid;
        logic          accept;
    } cap_t;

    cap_t cp_q, cp_d;
    logic [PW-1:0] pos;

    always_comb begin
        cand       = cp_q.bytes;
        cand[LAST] = in_data;
        cp_d = cp_q;
        pos  = in_sof ? '0 : cp_q.pos;
        if (in_valid) begin
            if (in_sof) cp_d.valid = 1'b0;
            if (pos < PW'(LAST)) begin
                cp_d.bytes[pos] = in_data;
            end else if (pos == PW'(LAST)) begin
                cp_d.valid  = 1'b1;
                cp_d.accept = promisc || hit;
            end
            if (pos < PW'(ADDR_BYTES)) cp_d.pos = pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp_q     <= '0;
            cp_q.pos <= PW'(ADDR_BYTES);
        end else begin
            cp_q <= cp_d;
        end
    end

    assign dec_valid  = cp_q.valid;
    assign dec_accept = cp_q.accept;
endmodule

// File: rtl/stn_filter.sv
module stn_filter
    import stn_filter_pkg::*;
#(
    parameter int N_ENT     = 16,
    parameter int ENT_BYTES = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       promisc,
    input  logic       setup_valid,
    input  logic       setup_last,
    input  logic [7:0] setup_data,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic [7:0] rx_data,
    output logic       match_valid,
    output logic       match_accept
);
    logic             commit;
    mac_t [N_ENT-1:0] shadow;
    mac_t             cand;
    logic             hit;

    setup_loader #(.N_ENT(N_ENT), .ENT_BYTES(ENT_BYTES)) u_ld (
        .clk(clk), .rst_n(rst_n),
        .in_valid(setup_valid), .in_last(setup_last), .in_data(setup_data),
        .commit(commit), .shadow(shadow)
    );

    addr_table #(.N_ENT(N_ENT)) u_tab (
        .clk(clk), .rst_n(rst_n),
        .load(commit), .load_tab(shadow), .cand(cand), .hit(hit)
    );

    dst_capture u_cap (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_sof(rx_sof), .in_data(rx_data),
        .promisc(promisc), .hit(hit), .cand(cand),
        .dec_valid(match_valid), .dec_accept(match_accept)
    );
endmodule

// File: rtl/stn_filter_chk.sv
module stn_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       promisc,
    input logic       setup_valid,
    input logic       setup_last,
    input logic       rx_valid,
    input logic       rx_sof,
    input logic       match_valid,
    input logic       match_accept
);
    logic seen_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         seen_last_q <= 1'b0;
        else if (setup_valid && setup_last) seen_last_q <= 1'b1;
    end

    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_sof |=> !match_valid);  // R8
    AST_DECISION_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid && !(rx_valid && rx_sof) |=> match_valid && $stable(match_accept));  // R8
    AST_RISE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_valid) |-> $past(rx_valid) && !$past(rx_sof));  // R8
    AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_valid) && $past(promisc) |-> match_accept);  // R7
    AST_EMPTY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_valid) && !seen_last_q && !$past(promisc) |-> !match_accept);  // R1
endmodule

bind stn_filter stn_filter_chk u_chk (.*);

// File: tb/sim_stn_filter.sv
module sim_stn_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       promisc = 1'b0;
    logic       setup_valid = 1'b0;
    logic       setup_last = 1'b0;
    logic [7:0] setup_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic [7:0] rx_data = '0;
    logic       match_valid;
    logic       match_accept;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [47:0] exp_tab [16];
    bit exp_loaded = 1'b0;

    always #10 clk = ~clk;

    stn_filter u0 (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [47:0] addr_of(input logic [7:0] seed, input int e);
        logic [7:0] eb = 8'(e);
        if (e == 0) return '1;
        return {8'h02, seed, 8'h10 + eb, (eb * 8'd37) ^ seed, 8'hA5, eb ^ 8'h3C};
    endfunction

    function automatic logic [7:0] pad_of(input int k);
        return 8'hC3 ^ 8'(k);
    endfunction

    function automatic logic exp_acc(input logic [47:0] d);
        if (promisc) return 1'b1;
        if (!exp_loaded) return 1'b0;
        for (int e = 0; e < 16; e++) if (exp_tab[e] == d) return 1'b1;
        return 1'b0;
    endfunction

    // R2 layout: slot e at 12e, address byte b at offset (b/2)*4 + b%2
    task automatic send_setup(input logic [7:0] seed, input int nbytes);
        for (int k = 0; k < nbytes; k++) begin
            int e = (k / 12) % 16;
            int o = k % 12;
            logic [47:0] a = addr_of(seed, e);
            @(negedge clk);
            setup_valid = 1'b1;
            setup_last  = (k == nbytes - 1);
            if ((o % 4) < 2) setup_data = a[47 - 8 * ((o / 4) * 2 + o % 2) -: 8];
            else             setup_data = pad_of(k);
        end
        @(negedge clk);
        setup_valid = 1'b0;
        setup_last  = 1'b0;
        if (nbytes == 192) begin
            exp_loaded = 1'b1;
            for (int e = 0; e < 16; e++) exp_tab[e] = addr_of(seed, e);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic send_rx(input logic [47:0] dst, input string req, input bit gap);
        logic exp;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (i == 1) chk("R8 cleared by sof", match_valid, 1'b0);
            if (i == 5) chk("R8 not early", match_valid, 1'b0);
            if (i == 6) begin
                chk("R8 valid after 6th", match_valid, 1'b1);
                chk(req, match_accept, exp);
            end
            if (i > 6) begin
                chk("R8 hold valid", match_valid, 1'b1);
                chk("R8 hold accept", match_accept, exp);
            end
            if (gap && i == 3) begin
                rx_valid = 1'b0;
                @(negedge clk);
            end
            if (i == 5) exp = exp_acc(dst);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_data  = (i < 6) ? dst[47 - 8 * i -: 8] : 8'hEE;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 hold idle", match_valid, 1'b1);
        chk("R8 hold idle accept", match_accept, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", match_valid, 1'b0);
        chk("R1 reset accept", match_accept, 1'b0);
        send_rx('1, "R1 empty rejects broadcast", 1'b0);
        promisc = 1'b1;
        send_rx(48'h123456789ABC, "R7 promisc empty table", 1'b0);
        promisc = 1'b0;

        send_setup(8'h01, 192);
        for (int e = 0; e < 16; e++) begin
            logic [47:0] pd;
            send_rx(addr_of(8'h01, e), "R2 R5 entry match", e[0]);
            send_rx(addr_of(8'h01, e) ^ (48'h1 << ((e * 7) % 48)), "R6 flipped bit rejects", 1'b0);
            for (int b = 0; b < 6; b++)
                pd[47 - 8 * b -: 8] = pad_of(e * 12 + (b / 2) * 4 + 2 + b % 2);
            send_rx(pd, "R3 padding bytes ignored", 1'b0);
        end

        send_setup(8'h02, 100);
        send_rx(addr_of(8'h01, 3), "R4 short frame keeps old", 1'b0);
        send_rx(addr_of(8'h02, 3), "R4 short frame not loaded", 1'b0);
        send_setup(8'h03, 193);
        send_rx(addr_of(8'h01, 7), "R4 long frame keeps old", 1'b0);
        send_rx(addr_of(8'h03, 7), "R4 long frame not loaded", 1'b0);

        send_setup(8'h04, 192);
        for (int e = 1; e < 16; e++) begin
            send_rx(addr_of(8'h01, e), "R9 old entry replaced", 1'b0);
            send_rx(addr_of(8'h04, e), "R9 new entry match", 1'b0);
        end
        promisc = 1'b1;
        send_rx(48'hDEAD_BEEF_0001, "R7 promisc override", 1'b1);
        promisc = 1'b0;
        send_rx(48'hDEAD_BEEF_0001, "R6 unknown rejects", 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule